// File: doc/BRIEF.md
# Condition Code Register Unit

This block holds the status flags of a small accumulator-based processor in one packed byte. After each ALU operation it updates the overflow, half-carry, negative, zero and carry flags. It works from the operands and the result that the datapath gives it, and from a 3-bit operation class. Flags that an operation class does not affect keep their value.

The block also owns the interrupt mask bit. Reset sets the mask. The mask is set again on interrupt entry, but only once the sequencer reports that register stacking is complete. A return-from-interrupt reloads the whole flag set from a restore byte. Software commands can set or clear the mask explicitly. The inverse of the mask leaves the block as a maskable-interrupt enable.

Top module: `ccr_unit`

## Requirements
- R1: The `ccr` byte is packed from bit 7 down to bit 0 as V, 1, 1, H, I, N, Z, C. Bits 6 and 5 always read 1, including after a restore whose byte has them at 0.
- R2: While `rst_n` is low and after it is released, I is 1 and V, H, N, Z, C are 0, so `ccr` reads 8'h68.
- R3: `op_class` 1 (add) and 2 (add with carry) set H when a carry leaves bit 3 and clear it otherwise. Classes 3, 4 and 5 leave H unchanged.
- R4: On classes 1 and 2, C becomes the carry out of bit 7 and V becomes the signed two's complement overflow of the addition.
- R5: On classes 3 (subtract) and 4 (subtract with borrow), C becomes the borrow out of bit 7 (operand a below operand b plus incoming C) and V becomes the signed overflow of the subtraction.
- R6: Classes 1 to 5 load N from bit 7 of `result` and set Z when `result` is zero. Class 5 (logic or move) clears V and leaves C unchanged.
- R7: Class 0 and the unused classes 6 and 7 leave V, H, N, Z and C unchanged.
- R8: A one-cycle `irq_enter` arms the entry. I is set on the clock edge that follows a later cycle with `stack_done` high while armed. A `stack_done` with no armed entry has no effect.
- R9: `restore` loads V, H, I, N, Z and C from bits 7, 4, 3, 2, 1, 0 of `restore_val`. It takes priority over an ALU update, the mask commands and entry completion in the same cycle.
- R10: `mask_set` sets I and `mask_clr` clears it. When both are asserted, the set wins. I falls only through `mask_clr` or `restore`.
- R11: `irq_en` always equals the inverse of `ccr[3]`, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 3 | 0 none, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-borrow, 5 logic/move |
| opnd_a | input | W | First ALU operand (accumulator) |
| opnd_b | input | W | Second ALU operand |
| result | input | W | ALU result for this operation |
| irq_enter | input | 1 | Interrupt entry has started |
| stack_done | input | 1 | Register stacking has completed |
| restore | input | 1 | Return-from-interrupt flag reload |
| restore_val | input | 8 | Byte pulled from the stack |
| mask_set | input | 1 | Set the interrupt mask |
| mask_clr | input | 1 | Clear the interrupt mask |
| ccr | output | 8 | Packed condition code byte |
| irq_en | output | 1 | Maskable interrupts allowed |

## Verification
On every cycle, the embedded assertions check the following: the way the mask may rise or fall, the exact reload on a restore, and that H and the other flags hold during operations that must not touch them. Only the bench's scenarios can show that the arithmetic is correct. Its sweeps over operand pairs for all four arithmetic classes compare each flag against values that the bench computes from integer sums. The timing of the arm-then-complete entry sequence and the combined priority cases are likewise shown only by directed scenarios.

// File: rtl/ccr_unit.sv
module ccr_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_class,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] result,
  input  logic         irq_enter,
  input  logic         stack_done,
  input  logic         restore,
  input  logic [7:0]   restore_val,
  input  logic         mask_set,
  input  logic         mask_clr,
  output logic [7:0]   ccr,
  output logic         irq_en
);

  localparam int MSB = W - 1;

  logic v, h, i, n, z, c, armed;

  wire is_add   = (op_class == 3'd1) || (op_class == 3'd2);
  wire is_sub   = (op_class == 3'd3) || (op_class == 3'd4);
  wire is_logic = (op_class == 3'd5);
  wire touch_nz = is_add || is_sub || is_logic;

  wire a7 = opnd_a[MSB];
  wire b7 = opnd_b[MSB];
  wire r7 = result[MSB];
  wire a3 = opnd_a[3];
  wire b3 = opnd_b[3];
  wire r3 = result[3];

  wire add_c = (a7 & b7) | (b7 & ~r7) | (~r7 & a7);
  wire add_v = (a7 & b7 & ~r7) | (~a7 & ~b7 & r7);
  wire add_h = (a3 & b3) | (b3 & ~r3) | (~r3 & a3);
  wire sub_c = (~a7 & b7) | (b7 & r7) | (r7 & ~a7);
  wire sub_v = (a7 & ~b7 & ~r7) | (~a7 & b7 & r7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v, h, n, z, c} <= '0;
    end else if (restore) begin
      v <= restore_val[7];
      h <= restore_val[4];
      n <= restore_val[2];
      z <= restore_val[1];
      c <= restore_val[0];
    end else begin
      if (touch_nz) begin
        n <= r7;
        z <= ~|result;
      end
      if (is_add) begin
        c <= add_c;
        v <= add_v;
        h <= add_h;
      end
      if (is_sub) begin
        c <= sub_c;
        v <= sub_v;
      end
      if (is_logic) v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i     <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (armed && stack_done) armed <= 1'b0;
      else if (irq_enter)      armed <= 1'b1;
      if (restore)                  i <= restore_val[3];
      else if (armed && stack_done) i <= 1'b1;
      else if (mask_set)            i <= 1'b1;
      else if (mask_clr)            i <= 1'b0;
    end
  end

  assign ccr    = {v, 2'b11, h, i, n, z, c};
  assign irq_en = ~ccr[3];

  // R8
  mask_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr[3]) |-> ($past(restore) || $past(mask_set) || $past(stack_done)));

  // R10
  mask_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ccr[3]) |-> ($past(restore) || $past(mask_clr)));

  // R9
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (ccr == ($past(restore_val) | 8'h60)));

  // R3
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && !is_add) |=> $stable(ccr[4]));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && !touch_nz) |=> ($stable(ccr[7]) && $stable(ccr[2:0])));

endmodule

// File: tb/ccr_unit_bench.sv
module ccr_unit_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [2:0] op_class;
  logic [7:0] opnd_a, opnd_b, result, restore_val;
  logic       irq_enter, stack_done, restore, mask_set, mask_clr;
  logic [7:0] ccr;
  logic       irq_en;

  ccr_unit #(.W(8)) u_ccr_unit (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .result(result), .irq_enter(irq_enter),
    .stack_done(stack_done), .restore(restore), .restore_val(restore_val),
    .mask_set(mask_set), .mask_clr(mask_clr), .ccr(ccr), .irq_en(irq_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic ev, eh, ei, en, ez, ec;

  function automatic logic [7:0] packed_exp();
    return {ev, 2'b11, eh, ei, en, ez, ec};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h (op %0d a %02h b %02h)",
               req, act, exp, op_class, opnd_a, opnd_b);
    end
  endtask

  task automatic idle();
    op_class = 3'd0; opnd_a = 0; opnd_b = 0; result = 0; restore_val = 0;
    irq_enter = 0; stack_done = 0; restore = 0; mask_set = 0; mask_clr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic arith(input logic [2:0] op, input int a, input int b);
    int cin, full, sa, sb, s;
    cin = (op == 3'd2 || op == 3'd4) ? int'(ec) : 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (op <= 3'd2) begin
      full = a + b + cin;
      s = sa + sb + cin;
      ec = (full > 255);
      eh = (((a & 15) + (b & 15) + cin) > 15);
    end else begin
      full = a - b - cin;
      s = sa - sb - cin;
      ec = (a < b + cin);
    end
    ev = (s > 127) || (s < -128);
    result = full[7:0];
    en = result[7];
    ez = (result == 0);
    op_class = op; opnd_a = a[7:0]; opnd_b = b[7:0];
    tick();
    check((op <= 3'd2) ? "R4/R3/R6" : "R5/R6", ccr, packed_exp());
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    tick(); tick();
    // R2
    check("R2", ccr, 8'h68);
    check("R11", {7'd0, irq_en}, 8'd0);
    rst_n = 1;
    tick();
    check("R2", ccr, 8'h68);
    ev = 0; eh = 0; ei = 1; en = 0; ez = 0; ec = 0;

    // R10 clear then both commands
    mask_clr = 1; tick(); mask_clr = 0; ei = 0;
    check("R10", ccr, packed_exp());
    check("R11", {7'd0, irq_en}, 8'd1);
    mask_set = 1; mask_clr = 1; tick(); idle(); ei = 1;
    check("R10", ccr, packed_exp());
    mask_clr = 1; tick(); idle(); ei = 0;

    // R8 stack_done alone ignored
    stack_done = 1; tick(); idle();
    check("R8", ccr, packed_exp());
    irq_enter = 1; tick(); idle();
    check("R8", ccr, packed_exp());
    tick();
    check("R8", ccr, packed_exp());
    stack_done = 1; tick(); idle(); ei = 1;
    check("R8", ccr, packed_exp());
    check("R11", {7'd0, irq_en}, 8'd0);

    // R9 restore beats ALU and mask command; R1 bits 6,5
    restore = 1; restore_val = 8'h00; op_class = 3'd1; opnd_a = 8'hFF;
    opnd_b = 8'hFF; result = 8'hFE; mask_set = 1;
    tick(); idle();
    ev = 0; eh = 0; ei = 0; en = 0; ez = 0; ec = 0;
    check("R9/R1", ccr, 8'h60);
    restore = 1; restore_val = 8'hFF; tick(); idle();
    ev = 1; eh = 1; ei = 1; en = 1; ez = 1; ec = 1;
    check("R9/R1", ccr, 8'hFF);

    // R7 unused classes hold
    for (int k = 0; k < 8; k++) begin
      if (k >= 1 && k <= 5) continue;
      op_class = k[2:0]; opnd_a = 8'h7F; opnd_b = 8'h01; result = 8'h00;
      tick();
      check("R7", ccr, packed_exp());
    end
    idle();

    // R6 logic class sweep: C and H kept, V cleared
    for (int r = 0; r < 256; r++) begin
      op_class = 3'd5; result = r[7:0];
      en = r[7]; ez = (r == 0); ev = 0;
      tick();
      check("R6", ccr, packed_exp());
    end
    idle();

    // R3 subtraction keeps H: set H via add, then subtract
    arith(3'd1, 8'h08, 8'h08);
    arith(3'd3, 8'h10, 8'h01);
    check("R3", {7'd0, ccr[4]}, 8'd1);

    // R4/R5 sweeps
    for (int op = 1; op <= 4; op++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b++)
          arith(op[2:0], a, b);
    idle();
    tick();
    check("R7", ccr, packed_exp());

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule